// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins, attached to a simple word-wide register bus. Software programs each pin as an input or an output. It writes the output latch that drives the pins set as outputs, and it reads back the live pin levels. Every input passes through a two-stage synchroniser. The synchronised value feeds the data readback and a per-pin event detector.

The trigger type is chosen when the block is built, through the `TRIG` parameter, and cannot be changed by software. The choices are rising edge, falling edge, either edge, or level-high. In the three edge modes, detected events set bits in a sticky capture register. Software clears those bits by writing ones. The single interrupt line is the OR of the captured bits ANDed with the per-pin mask. In level-high mode the interrupt instead follows the live synchronised pin levels ANDed with the mask. In that mode the capture register still records rising edges, but the interrupt does not use it.

The block has no state machine. It is built from register stages: a synchroniser, an event detector, a capture register and a register file with a registered read port.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, the output latch, the direction, mask and capture registers are all zero, `pin_oe` is zero and `irq` is low.
- R2: Word address 0 selects data, 1 selects direction, 2 selects the interrupt mask and 3 selects the capture register.
- R3: A write to address 0 loads the output latch seen on `pin_out` at the next clock. A write to address 1 loads `pin_oe` at the next clock, where bit value 1 makes that pin an output.
- R4: A read of address 0 returns `pin_in` after a two-flop synchroniser. A read sampled at the first or second clock edge after a pin change returns the old value, and one sampled at the third edge returns the new value. `rdata` is registered and updates at the clock edge where `rd_en` is high.
- R5: Register bits at positions `NPINS` and above read as zero, and writes to them have no effect.
- R6: A capture bit is set by a 0-to-1 transition of the synchronised input in rising mode, by a 1-to-0 transition in falling mode, and by either in both-edge mode. Level mode records rising transitions. The bit is set at the third clock edge after the pin change.
- R7: Writing 1 to a capture bit clears it, and writing 0 leaves it unchanged.
- R8: When an event arrives on a bit in the same cycle as a write that clears it, the bit stays set. Clears of other bits in that write still take effect.
- R9: In the edge modes, `irq` is high exactly when some capture bit and its mask bit are both 1.
- R10: In level mode, `irq` is high exactly when some synchronised pin and its mask bit are both 1, whatever the capture register holds.
- R11: A zero mask keeps `irq` low in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pin levels from the pads |
| pin_out | output | NPINS | Output latch value for the pads |
| pin_oe | output | NPINS | Per-pin output enable (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
All four trigger variants are instantiated side by side and driven with the same pin waveforms.

A rise on four pins followed by a fall on two of them separates the rising, falling and both-edge captures from one another. Masking a pin that has a captured edge but is now low separates the captured-event interrupt from the level interrupt.

Back-to-back reads right after a pin change expose the synchroniser depth. A clearing write timed onto the exact cycle of a fresh edge shows whether the edge or the clear wins, and whether a clear of a neighbouring bit still takes effect.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_MASK = 2'd2,
        REG_CAP  = 2'd3
    } reg_sel_e;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 2;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q[i] <= 1'b0;
                stage2_q[i] <= 1'b0;
            end else begin
                stage1_q[i] <= async_in[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int    W    = 32,
    parameter trig_e TRIG = TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    output logic [W-1:0] evt
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= cur;
        end
    end

    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;

    if (TRIG == TRIG_FALL) begin : g_fall
        assign evt = fall;
    end else if (TRIG == TRIG_BOTH) begin : g_both
        assign evt = rise | fall;
    end else begin : g_rise
        assign evt = rise;
    end

endmodule

// File: rtl/gpio_capture.sv
module gpio_capture #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cap
);

    logic [W-1:0] cap_q;
    logic [W-1:0] cap_d;

    always_comb begin
        cap_d = (cap_q & ~clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign cap = cap_q;

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int    NPINS = 32,
    parameter trig_e TRIG  = TRIG_RISE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    input  logic [NPINS-1:0]      pin_in,
    output logic [NPINS-1:0]      pin_out,
    output logic [NPINS-1:0]      pin_oe,
    output logic                  irq
);

    localparam bit LEVEL_MODE = (TRIG == TRIG_LEVEL);

    reg_sel_e         sel;
    logic [NPINS-1:0] wr_bits;
    logic [NPINS-1:0] pin_sync;
    logic [NPINS-1:0] edge_evt;
    logic [NPINS-1:0] cap_q;
    logic [NPINS-1:0] cap_clr;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] rd_sel;
    logic [BUS_W-1:0] rdata_q;
    logic [BUS_W-1:0] unused_wdata_hi;

    assign sel             = reg_sel_e'(addr);
    assign wr_bits         = wdata[NPINS-1:0];
    assign unused_wdata_hi = wdata >> NPINS;

    gpio_sync #(.W(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_edge_detect #(.W(NPINS), .TRIG(TRIG)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .cur   (pin_sync),
        .evt   (edge_evt)
    );

    assign cap_clr = (wr_en && sel == REG_CAP) ? wr_bits : '0;

    gpio_capture #(.W(NPINS)) u_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (edge_evt),
        .clr   (cap_clr),
        .cap   (cap_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                REG_DATA: out_q  <= wr_bits;
                REG_DIR:  dir_q  <= wr_bits;
                REG_MASK: mask_q <= wr_bits;
                REG_CAP:  ;
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            REG_DATA: rd_sel = pin_sync;
            REG_DIR:  rd_sel = dir_q;
            REG_MASK: rd_sel = mask_q;
            REG_CAP:  rd_sel = cap_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= BUS_W'(rd_sel);
        end
    end

    if (LEVEL_MODE) begin : g_irq_level
        assign irq = |(pin_sync & mask_q);
    end else begin : g_irq_edge
        assign irq = |(cap_q & mask_q);
    end

    assign rdata   = rdata_q;
    assign pin_out = out_q;
    assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic [31:0]      wdata,
    input logic [31:0]      rdata,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] mask,
    input logic [NPINS-1:0] cap,
    input logic [NPINS-1:0] evt
);

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_oe == '0 && cap == '0 && pin_out == '0)); // R1

    AST_OE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd1) |=> pin_oe == $past(wdata[NPINS-1:0])); // R3

    AST_OUT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 2'd0) |=> pin_out == $past(wdata[NPINS-1:0])); // R3

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata >> NPINS) == 32'd0); // R5

    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == 2'd3) && evt == '0) |=> $stable(cap)); // R7

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((cap & $past(evt)) == $past(evt))); // R8

    AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R11

endmodule

bind gpio_edge_port gpio_edge_port_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq),
    .mask    (mask_q),
    .cap     (cap_q),
    .evt     (edge_evt)
);

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;
    import gpio_edge_pkg::*;

    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [31:0]  wdata = 32'd0;
    logic [N-1:0] pin_in = '0;

    logic [31:0]  rdata_r, rdata_f, rdata_b, rdata_l;
    logic [N-1:0] out_r, out_f, out_b, out_l;
    logic [N-1:0] oe_r, oe_f, oe_b, oe_l;
    logic         irq_r, irq_f, irq_b, irq_l;

    logic [31:0]  rd_r, rd_f, rd_b, rd_l;
    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_port #(.NPINS(N), .TRIG(TRIG_RISE)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_r), .pin_in(pin_in), .pin_out(out_r),
        .pin_oe(oe_r), .irq(irq_r));
    gpio_edge_port #(.NPINS(N), .TRIG(TRIG_FALL)) u_fall (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_f), .pin_in(pin_in), .pin_out(out_f),
        .pin_oe(oe_f), .irq(irq_f));
    gpio_edge_port #(.NPINS(N), .TRIG(TRIG_BOTH)) u_both (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_b), .pin_in(pin_in), .pin_out(out_b),
        .pin_oe(oe_b), .irq(irq_b));
    gpio_edge_port #(.NPINS(N), .TRIG(TRIG_LEVEL)) u_lvl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata_l), .pin_in(pin_in), .pin_out(out_l),
        .pin_oe(oe_l), .irq(irq_l));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 32'd0;
    endtask

    task automatic bus_read(input logic [1:0] a);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        rd_r = rdata_r; rd_f = rdata_f; rd_b = rdata_b; rd_l = rdata_l;
    endtask

    task automatic set_pins(input logic [N-1:0] v, input int wait_cycles);
        pin_in = v;
        repeat (wait_cycles) @(negedge clk);
    endtask

    task automatic t_reset;
        bus_read(2'd1); check("R1 dir after reset", rd_r, 32'd0);
        bus_read(2'd2); check("R1 mask after reset", rd_r, 32'd0);
        bus_read(2'd3); check("R1 capture after reset", rd_r, 32'd0);
        check("R1 pin_oe after reset", 32'(oe_r), 32'd0);
        check("R1 pin_out after reset", 32'(out_r), 32'd0);
        check("R1 irq after reset", {28'd0, irq_r, irq_f, irq_b, irq_l}, 32'd0);
    endtask

    task automatic t_dir_out;
        bus_write(2'd0, 32'hFFFF_FA5A);
        check("R3 pin_out after data write", 32'(out_r), 32'h0000_0A5A);
        bus_write(2'd1, 32'hFFFF_00F0);
        check("R3 pin_oe after dir write", 32'(oe_r), 32'h0000_00F0);
        bus_read(2'd1);
        check("R2 R5 dir readback", rd_r, 32'h0000_00F0);
        bus_write(2'd2, 32'hFFFF_F000);
        bus_read(2'd2);
        check("R5 mask high bits ignored", rd_r, 32'd0);
        bus_write(2'd2, 32'hFFFF_FFFF);
        bus_read(2'd2);
        check("R2 R5 mask readback", rd_r, 32'h0000_0FFF);
        bus_write(2'd2, 32'd0);
    endtask

    task automatic t_readback;
        pin_in = 12'hA5C;
        bus_read(2'd0); check("R4 read at first edge old", rd_r, 32'd0);
        bus_read(2'd0); check("R4 read at second edge old", rd_r, 32'd0);
        bus_read(2'd0); check("R4 read at third edge new", rd_r, 32'h0000_0A5C);
        set_pins('0, 4);
        bus_write(2'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_edges;
        set_pins(12'h00F, 4);
        bus_read(2'd3);
        check("R6 rise capture", rd_r, 32'h00F);
        check("R6 fall capture", rd_f, 32'h000);
        check("R6 both capture", rd_b, 32'h00F);
        check("R6 level capture", rd_l, 32'h00F);
        set_pins(12'h003, 4);
        bus_read(2'd3);
        check("R6 rise capture after fall", rd_r, 32'h00F);
        check("R6 fall capture after fall", rd_f, 32'h00C);
        check("R6 both capture after fall", rd_b, 32'h00F);
        check("R11 irq masked", {28'd0, irq_r, irq_f, irq_b, irq_l}, 32'd0);
        bus_write(2'd2, 32'h004);
        check("R9 irq edge modes bit2", {29'd0, irq_r, irq_f, irq_b}, 32'h7);
        check("R10 level irq ignores capture", {31'd0, irq_l}, 32'd0);
        bus_write(2'd2, 32'h001);
        check("R9 irq mask bit0", {29'd0, irq_r, irq_f, irq_b}, 32'h5);
        check("R10 level irq pin high", {31'd0, irq_l}, 32'd1);
        set_pins(12'h002, 3);
        check("R10 level irq follows pin low", {31'd0, irq_l}, 32'd0);
        check("R9 rise irq held by capture", {31'd0, irq_r}, 32'd1);
        set_pins(12'h003, 3);
        check("R10 level irq pin back high", {31'd0, irq_l}, 32'd1);
    endtask

    task automatic t_w1c;
        bus_write(2'd3, 32'd0);
        bus_read(2'd3);
        check("R7 zero write keeps capture", rd_r, 32'h00F);
        bus_write(2'd3, 32'h00D);
        bus_read(2'd3);
        check("R7 ones clear capture", rd_r, 32'h002);
        check("R9 irq drops after clear", {31'd0, irq_r}, 32'd0);
        bus_write(2'd2, 32'd0);
        bus_write(2'd3, 32'hFFF);
    endtask

    task automatic t_collision;
        set_pins('0, 4);
        set_pins(12'h002, 4);
        bus_write(2'd3, 32'h001);
        bus_read(2'd3);
        check("R8 setup bit1 captured", rd_r, 32'h002);
        pin_in = 12'h003;
        @(negedge clk);
        @(negedge clk);
        bus_write(2'd3, 32'h003);
        bus_read(2'd3);
        check("R8 edge wins over same-cycle clear", rd_r, 32'h001);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_readback();
        t_edges();
        t_w1c();
        t_collision();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule